// File: doc/BRIEF.md
# Global 64-bit Counter with Periodic Comparator

This block is a system timer. It holds a 64-bit up-counter that runs freely while a start bit is set, together with one 64-bit comparator. When the comparator is enabled and equals the counter, a sticky event flag is raised. The interrupt output is that flag masked by an enable bit. In periodic mode the comparator adds a programmed 32-bit step to itself on every match, so events repeat at a fixed period and software never has to reload it.

Software reaches the block through a plain 32-bit register port. A write strobe is taken on every cycle it is high, there is no back-pressure, and read data is a combinational function of the address. Writes to the counter halves, the comparator halves, the step and the control word pass through a fixed synchronisation delay before they take effect. Each such write then raises its own sticky status bit, which software polls and clears by writing 1. The counter halves are read live, so a 64-bit read takes the form high, low, high, and is retried if the two high words differ.

Top module: `sys_cmp_timer`

Register word addresses: 0 counter low, 1 counter high, 2 comparator low, 3 comparator high, 4 step, 5 control (bit 0 compare enable, bit 1 auto-step, bit 8 run), 6 interrupt enable (bit 0), 7 event flag (bit 0), 8 write status, 9 counter write status.

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: A write to addresses 0 to 5 changes the register exactly 3 cycles after the cycle in which the strobe is sampled. Until then the old value reads back.
- R3: When a delayed write takes effect, its status bit is set. At address 8 these are bit 0 comparator low, bit 1 comparator high, bit 2 step and bit 16 control. At address 9 they are bit 0 counter low and bit 1 counter high. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R4: While control bit 8 is set, the counter advances by one each cycle, carrying from the low word into the high word and wrapping at 2^64. While bit 8 is clear it holds its value.
- R5: When control bit 0 is set and the counter equals the comparator, the event flag (address 7 bit 0) is set on the next clock edge. With bit 0 clear no event occurs, even if bit 1 is set.
- R6: With control bit 1 clear, a match leaves the comparator unchanged, and no further event occurs until the counter meets it again.
- R7: With control bits 0 and 1 set, each match adds the step value to the comparator, so successive events are exactly step cycles apart.
- R8: Writing 1 to address 7 bit 0 clears the event flag. A match in the same cycle wins, and the flag stays set.
- R9: `irq` is high exactly when the event flag and interrupt enable bit 0 are both set.
- R10: Reads of unmapped addresses (10 to 15) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, taken every cycle it is high |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
Two things can coincide in one cycle: a comparator match that sets the event flag, and a software write-1 that clears the same flag. The bench provokes this deterministically by stopping the counter at the comparator value with compare enabled, so a match is present in every cycle. It then issues the clear and expects the flag to read back set. With compare disabled, the same clear must bring the flag to zero. Periodic spacing is judged separately by a scoreboard of expected event intervals.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  localparam int REG_W  = 32;
  localparam int CNT_W  = 2 * REG_W;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd1;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 4'd3;
  localparam logic [ADDR_W-1:0] A_STEP   = 4'd4;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd5;
  localparam logic [ADDR_W-1:0] A_IEN    = 4'd6;
  localparam logic [ADDR_W-1:0] A_FLAG   = 4'd7;
  localparam logic [ADDR_W-1:0] A_WST    = 4'd8;
  localparam logic [ADDR_W-1:0] A_CWST   = 4'd9;

  localparam int CTRL_CEN  = 0;
  localparam int CTRL_AUTO = 1;
  localparam int CTRL_RUN  = 8;

  localparam int WST_CMPLO = 0;
  localparam int WST_CMPHI = 1;
  localparam int WST_STEP  = 2;
  localparam int WST_CTRL  = 16;

  typedef struct packed {
    logic run;
    logic auto_step;
    logic cen;
  } ctrl_t;
endpackage

// File: rtl/gtc_wr_delay.sv
module gtc_wr_delay #(
  parameter int DLY = 3,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          out_vld,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);
  logic          vld_q  [DLY];
  logic [AW-1:0] addr_q [DLY];
  logic [DW-1:0] data_q [DLY];

  for (genvar g = 0; g < DLY; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[g]  <= 1'b0;
          addr_q[g] <= '0;
          data_q[g] <= '0;
        end else begin
          vld_q[g]  <= in_vld;
          addr_q[g] <= in_addr;
          data_q[g] <= in_data;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[g]  <= 1'b0;
          addr_q[g] <= '0;
          data_q[g] <= '0;
        end else begin
          vld_q[g]  <= vld_q[g-1];
          addr_q[g] <= addr_q[g-1];
          data_q[g] <= data_q[g-1];
        end
      end
    end
  end

  // the last stage is presented combinationally; the consumer registers it,
  // so a write sampled at edge k lands at edge k+DLY
  assign out_vld  = vld_q[DLY-1];
  assign out_addr = addr_q[DLY-1];
  assign out_data = data_q[DLY-1];
endmodule

// File: rtl/gtc_counter.sv
module gtc_counter #(
  parameter int HALF_W = 32,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] ld_data,
  output logic [FULL_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ld_lo) begin
      cnt <= {cnt[FULL_W-1:HALF_W], ld_data};
    end else if (ld_hi) begin
      cnt <= {ld_data, cnt[HALF_W-1:0]};
    end else if (run) begin
      cnt <= cnt + FULL_W'(1);
    end
  end
endmodule

// File: rtl/gtc_compare.sv
module gtc_compare #(
  parameter int HALF_W = 32,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FULL_W-1:0] cnt,
  input  logic              cen,
  input  logic              auto_step,
  input  logic [HALF_W-1:0] step,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [FULL_W-1:0] cmp,
  output logic              match
);
  assign match = cen && (cnt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp <= '0;
    end else if (wr_lo) begin
      cmp <= {cmp[FULL_W-1:HALF_W], wdata};
    end else if (wr_hi) begin
      cmp <= {wdata, cmp[HALF_W-1:0]};
    end else if (match && auto_step) begin
      cmp <= cmp + FULL_W'(step);
    end
  end
endmodule

// File: rtl/sys_cmp_timer.sv
module sys_cmp_timer
  import gtc_pkg::*;
#(
  parameter int WR_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  logic              ap_vld;
  logic [ADDR_W-1:0] ap_addr;
  logic [REG_W-1:0]  ap_data;
  logic              dly_in;

  assign dly_in = bus_wr && (bus_addr <= A_CTRL);

  gtc_wr_delay #(.DLY(WR_DELAY), .AW(ADDR_W), .DW(REG_W)) u_dly (
    .clk(clk), .rst_n(rst_n),
    .in_vld(dly_in), .in_addr(bus_addr), .in_data(bus_wdata),
    .out_vld(ap_vld), .out_addr(ap_addr), .out_data(ap_data)
  );

  logic ap_cnt_lo, ap_cnt_hi, ap_cmp_lo, ap_cmp_hi, ap_step, ap_ctrl;
  assign ap_cnt_lo = ap_vld && (ap_addr == A_CNT_LO);
  assign ap_cnt_hi = ap_vld && (ap_addr == A_CNT_HI);
  assign ap_cmp_lo = ap_vld && (ap_addr == A_CMP_LO);
  assign ap_cmp_hi = ap_vld && (ap_addr == A_CMP_HI);
  assign ap_step   = ap_vld && (ap_addr == A_STEP);
  assign ap_ctrl   = ap_vld && (ap_addr == A_CTRL);

  ctrl_t            ctrl_q;
  logic [REG_W-1:0] step_q;
  logic             ien_q;
  logic             flag_q;
  logic [3:0]       wst_q;
  logic [1:0]       cwst_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic             match;

  gtc_counter #(.HALF_W(REG_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run),
    .ld_lo(ap_cnt_lo), .ld_hi(ap_cnt_hi), .ld_data(ap_data), .cnt(cnt)
  );

  gtc_compare #(.HALF_W(REG_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt),
    .cen(ctrl_q.cen), .auto_step(ctrl_q.auto_step), .step(step_q),
    .wr_lo(ap_cmp_lo), .wr_hi(ap_cmp_hi), .wdata(ap_data),
    .cmp(cmp), .match(match)
  );

  // software clear strobes (write-1-to-clear, immediate)
  logic       flag_clr;
  logic [3:0] wst_clr;
  logic [3:0] wst_set;
  logic [1:0] cwst_clr;
  logic [1:0] cwst_set;

  assign flag_clr = bus_wr && (bus_addr == A_FLAG) && bus_wdata[0];
  assign wst_clr  = (bus_wr && (bus_addr == A_WST)) ?
                    {bus_wdata[WST_CTRL], bus_wdata[WST_STEP],
                     bus_wdata[WST_CMPHI], bus_wdata[WST_CMPLO]} : 4'b0;
  assign cwst_clr = (bus_wr && (bus_addr == A_CWST)) ? bus_wdata[1:0] : 2'b0;
  assign wst_set  = {ap_ctrl, ap_step, ap_cmp_hi, ap_cmp_lo};
  assign cwst_set = {ap_cnt_hi, ap_cnt_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      step_q <= '0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
      wst_q  <= '0;
      cwst_q <= '0;
    end else begin
      if (ap_ctrl) begin
        ctrl_q.run       <= ap_data[CTRL_RUN];
        ctrl_q.auto_step <= ap_data[CTRL_AUTO];
        ctrl_q.cen       <= ap_data[CTRL_CEN];
      end
      if (ap_step) step_q <= ap_data;
      if (bus_wr && (bus_addr == A_IEN)) ien_q <= bus_wdata[0];
      if (match)         flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      wst_q  <= (wst_q & ~wst_clr) | wst_set;
      cwst_q <= (cwst_q & ~cwst_clr) | cwst_set;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt[REG_W-1:0];
      A_CNT_HI: bus_rdata = cnt[CNT_W-1:REG_W];
      A_CMP_LO: bus_rdata = cmp[REG_W-1:0];
      A_CMP_HI: bus_rdata = cmp[CNT_W-1:REG_W];
      A_STEP:   bus_rdata = step_q;
      A_CTRL: begin
        bus_rdata[CTRL_RUN]  = ctrl_q.run;
        bus_rdata[CTRL_AUTO] = ctrl_q.auto_step;
        bus_rdata[CTRL_CEN]  = ctrl_q.cen;
      end
      A_IEN:  bus_rdata[0] = ien_q;
      A_FLAG: bus_rdata[0] = flag_q;
      A_WST: begin
        bus_rdata[WST_CMPLO] = wst_q[0];
        bus_rdata[WST_CMPHI] = wst_q[1];
        bus_rdata[WST_STEP]  = wst_q[2];
        bus_rdata[WST_CTRL]  = wst_q[3];
      end
      A_CWST:  bus_rdata[1:0] = cwst_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = flag_q && ien_q;
endmodule

// File: rtl/gtc_chk.sv
module gtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] cnt,
  input logic [63:0] cmp,
  input logic        run,
  input logic        cen,
  input logic        auto_step,
  input logic [31:0] step,
  input logic        match,
  input logic        cnt_ld,
  input logic        cmp_ld,
  input logic        flag,
  input logic        flag_clr
);
  // R4
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_ld) |=> (cnt == $past(cnt) + 64'd1));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_ld) |=> $stable(cnt));

  // R5
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && (cnt == cmp)) |=> flag);

  // R6
  oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !auto_step && !cmp_ld) |=> $stable(cmp));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && auto_step && !cmp_ld) |=> (cmp == $past(cmp) + {32'd0, $past(step)}));

  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match) |=> !flag);
endmodule

bind sys_cmp_timer gtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(cmp),
  .run(ctrl_q.run), .cen(ctrl_q.cen), .auto_step(ctrl_q.auto_step),
  .step(step_q), .match(match),
  .cnt_ld(ap_cnt_lo || ap_cnt_hi), .cmp_ld(ap_cmp_lo || ap_cmp_hi),
  .flag(flag_q), .flag_clr(flag_clr)
);

// File: tb/sys_cmp_timer_test.sv
module sys_cmp_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  longint cyc = 0;
  int exp_q[$];
  bit mon_on = 1'b0;

  sys_cmp_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(input int limit, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // scoreboard monitor: interval between event rises
  initial begin
    bit have_prev = 1'b0;
    bit last_irq = 1'b0;
    longint prev_cyc = 0;
    forever begin
      @(negedge clk);
      if (mon_on && irq && !last_irq) begin
        if (have_prev && exp_q.size() > 0)
          chk("R7 period", 64'(cyc - prev_cyc), 64'(exp_q.pop_front()));
        have_prev = 1'b1;
        prev_cyc = cyc;
      end
      last_irq = irq;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2, h1, h2;
    bit seen;
    longint t0;

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      chk("R1 reset reg", 64'(v), 64'd0);
    end
    chk("R1 irq low", 64'(irq), 64'd0);

    // R2 delayed effect, R3 write status
    wr(4'd2, 32'h55);
    idle(2);
    rd(4'd2, v);
    chk("R2 before delay", 64'(v), 64'd0);
    rd(4'd8, v);
    chk("R3 status not yet", 64'(v), 64'd0);
    idle(1);
    rd(4'd2, v);
    chk("R2 after delay", 64'(v), 64'h55);
    rd(4'd8, v);
    chk("R3 cmp lo status", 64'(v), 64'h1);
    wr(4'd8, 32'h0);
    rd(4'd8, v);
    chk("R3 write 0 keeps", 64'(v), 64'h1);
    wr(4'd8, 32'h1);
    rd(4'd8, v);
    chk("R3 w1c clears", 64'(v), 64'h0);
    wr(4'd5, 32'h0);
    wr(4'd4, 32'd7);
    idle(4);
    rd(4'd8, v);
    chk("R3 ctrl+step status", 64'(v), 64'h10004);
    wr(4'd8, 32'h10004);

    // R4 counter held while stopped, then runs with carry
    wr(4'd0, 32'hFFFF_FFF0);
    wr(4'd1, 32'd5);
    idle(4);
    rd(4'd0, v);
    chk("R4 held lo", 64'(v), 64'hFFFF_FFF0);
    rd(4'd1, v);
    chk("R4 held hi", 64'(v), 64'd5);
    rd(4'd9, v);
    chk("R3 counter status", 64'(v), 64'h3);
    wr(4'd9, 32'h1);
    rd(4'd9, v);
    chk("R3 counter status partial", 64'(v), 64'h2);
    wr(4'd9, 32'h2);
    wr(4'd5, 32'h100);
    idle(40);
    rd(4'd1, h1); rd(4'd0, v); rd(4'd1, h2);
    chk("R4 carry into hi", 64'(h1), 64'd6);
    chk("R4 hi consistent", 64'(h2), 64'd6);
    rd(4'd0, v);
    idle(10);
    rd(4'd0, v2);
    chk("R4 rate", 64'(v2 - v), 64'd10);
    wr(4'd5, 32'h0);
    idle(4);
    rd(4'd0, v);
    idle(5);
    rd(4'd0, v2);
    chk("R4 stopped holds", 64'(v2), 64'(v));

    // R4 64-bit wrap
    wr(4'd0, 32'hFFFF_FFF8);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd5, 32'h100);
    idle(20);
    rd(4'd1, h1);
    chk("R4 wrap hi", 64'(h1), 64'd0);
    wr(4'd5, 32'h0);
    idle(4);

    // R5 timing, R9 gating, R6 one-shot
    wr(4'd0, 32'd0);
    wr(4'd1, 32'd0);
    wr(4'd3, 32'd0);
    wr(4'd2, 32'd100);
    wr(4'd6, 32'd1);
    idle(4);
    wr(4'd5, 32'h101);
    t0 = cyc;
    wait_irq(300, seen);
    chk("R5 event seen", 64'(seen), 64'd1);
    chk("R5 event timing", 64'(cyc - t0), 64'd104);
    rd(4'd2, v);
    chk("R6 cmp unchanged", 64'(v), 64'd100);
    wr(4'd6, 32'd0);
    chk("R9 masked irq", 64'(irq), 64'd0);
    rd(4'd7, v);
    chk("R9 flag still set", 64'(v), 64'd1);
    wr(4'd6, 32'd1);
    chk("R9 irq again", 64'(irq), 64'd1);
    wr(4'd7, 32'd1);
    chk("R8 cleared", 64'(irq), 64'd0);
    wait_irq(300, seen);
    chk("R6 no repeat", 64'(seen), 64'd0);

    // R5 disabled compare; R8 coincident set/clear
    wr(4'd5, 32'h002);
    wr(4'd0, 32'd100);
    wr(4'd1, 32'd0);
    idle(6);
    rd(4'd7, v);
    chk("R5 auto without enable no event", 64'(v), 64'd0);
    wr(4'd5, 32'h001);
    idle(4);
    wr(4'd7, 32'd1);
    rd(4'd7, v);
    chk("R8 match beats clear", 64'(v), 64'd1);
    wr(4'd5, 32'h000);
    idle(4);
    wr(4'd7, 32'd1);
    rd(4'd7, v);
    chk("R8 clear without match", 64'(v), 64'd0);

    // R7 periodic, scoreboard
    wr(4'd0, 32'd0);
    wr(4'd2, 32'd30);
    wr(4'd4, 32'd50);
    idle(4);
    for (int i = 0; i < 4; i++) exp_q.push_back(50);
    mon_on = 1'b1;
    wr(4'd5, 32'h103);
    for (int i = 0; i < 5; i++) begin
      wait_irq(200, seen);
      chk("R7 periodic event", 64'(seen), 64'd1);
      wr(4'd7, 32'd1);
    end
    wr(4'd5, 32'h000);
    idle(4);
    mon_on = 1'b0;
    chk("R7 all periods seen", 64'(exp_q.size()), 64'd0);
    rd(4'd2, v);
    chk("R7 cmp stepped", 64'(v), 64'd280);

    // R10 unmapped
    wr(4'd12, 32'hDEAD_BEEF);
    idle(4);
    rd(4'd12, v);
    chk("R10 unmapped reads 0", 64'(v), 64'd0);
    rd(4'd6, v);
    chk("R10 ien intact", 64'(v), 64'd1);
    rd(4'd4, v);
    chk("R10 step intact", 64'(v), 64'd50);
    rd(4'd5, v);
    chk("R10 ctrl intact", 64'(v), 64'd0);

    finish_run();
  end
endmodule